// File: doc/BRIEF.md
# Two-Operand ALU with Per-Operation Flag Rules

This block is the execute stage for the two-operand instruction class of a small 16-bit processor. Operand fetch happens upstream. Each valid cycle the block receives a source value, a destination value, a 4-bit operation code, a byte/word select and the current carry flag. One clock later it presents the result and a writeback strobe. It also presents the new overflow (V), negative (N), zero (Z) and carry (C) flag values, each with its own update strobe. The register file and status register consume these outputs directly.

Each operation carries its own flag policy:

- Some operations update all four flags.
- The logic operations clear overflow and derive carry from zero.
- Moves and bit set/clear leave the flags alone.
- Compare and bit-test produce flags but no writeback.

Subtraction is formed as destination plus inverted source, plus one or plus the incoming carry. A packed-BCD add with carry is included. In byte mode only the low eight bits take part, and the upper result byte is forced to zero.

Top module: `dual_operand_alu`

## Requirements
- R1: With `byte_mode`=1, only bits 7:0 of `src` and `dst` are used. `result[15:8]` is 0, N is taken from bit 7, and C is the carry out of bit 7. With `byte_mode`=0 the full 16 bits are used, N is bit 15 and C is the carry out of bit 15.
- R2: Opcode 0 (move) gives result = src with `wb_en`=1, and none of the four flag update strobes is asserted.
- R3: Opcode 1 (add) gives dst+src, and opcode 2 (add with carry) gives dst+src+`carry_in`. Both write back and update V, N, Z and C. V is set when both addends have the same sign bit and the result's sign differs from it.
- R4: Opcode 3 (subtract) gives dst+~src+1, and opcode 4 (subtract with carry) gives dst+~src+`carry_in`. Both write back and update all four flags. V uses the R3 rule with ~src as the addend, and C is the carry out.
- R5: Opcode 5 (compare) computes dst+~src+1 on `result` and updates all four flags as opcode 3 does, but keeps `wb_en`=0.
- R6: Opcode 6 (decimal add) treats the operands as packed BCD (4 digits in word mode, 2 in byte mode) and adds dst+src+`carry_in` decimally. C is set when the decimal sum exceeds 9999 (word) or 99 (byte), and the result is the sum modulo 10000 or 100. All four flags are updated, with V following the R3 rule on src and dst.
- R7: Opcode 11 (and) writes src&dst. Opcode 7 (bit test) computes src&dst with `wb_en`=0. Both update all flags, with V=0 and C = not Z.
- R8: Opcode 8 (bit clear) writes ~src&dst and opcode 9 (bit set) writes src|dst. Neither asserts any flag update strobe.
- R9: Opcode 10 (exclusive or) writes src^dst and updates all four flags. V is set when both operands are negative, and C = not Z.
- R10: Outputs appear exactly one clock after the cycle in which `in_valid` is high, with `out_valid`=1. In any cycle with `out_valid`=0, `result`, `wb_en`, all flag values and all update strobes are 0.
- R11: A flag value output is 0 whenever its update strobe is 0.
- R12: Opcodes 12 to 15 are reserved. They give `result`=0, `wb_en`=0 and no flag update strobe.
- R13: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 4 | Operation code |
| byte_mode | input | 1 | 1 = 8-bit operation, 0 = 16-bit operation |
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Registered outputs are valid |
| result | output | 16 | Operation result |
| wb_en | output | 1 | Destination must be written with `result` |
| flag_v | output | 1 | New overflow flag |
| flag_n | output | 1 | New negative flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |
| upd_v | output | 1 | Overflow flag must be updated |
| upd_n | output | 1 | Negative flag must be updated |
| upd_z | output | 1 | Zero flag must be updated |
| upd_c | output | 1 | Carry flag must be updated |

## Verification
The assertions compare each registered output with the `in_valid`, `op` and `byte_mode` values seen one cycle earlier. They therefore assume that reset holds `in_valid` low, so that no operation is accepted during reset. The decimal-add rule is meaningful only for valid BCD digits. Every decimal-add vector in the stimulus is therefore built digit by digit from values 0 to 9, while all other operations take unconstrained 16-bit operands, including garbage in the upper byte during byte-mode runs. Idle cycles are interleaved with the operations so that the cleared-output rule is exercised between results.

// File: rtl/dual_operand_alu.sv
module dual_operand_alu #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic          byte_mode,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dst,
  input  logic          carry_in,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          wb_en,
  output logic          flag_v,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_c,
  output logic          upd_v,
  output logic          upd_n,
  output logic          upd_z,
  output logic          upd_c
);
  localparam int HW  = DW / 2;
  localparam int ND  = DW / 4;
  localparam int NDH = HW / 4;

  localparam logic [3:0] OP_MOV  = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_ADDC = 4'd2;
  localparam logic [3:0] OP_SUB  = 4'd3;
  localparam logic [3:0] OP_SUBC = 4'd4;
  localparam logic [3:0] OP_CMP  = 4'd5;
  localparam logic [3:0] OP_DADD = 4'd6;
  localparam logic [3:0] OP_BIT  = 4'd7;
  localparam logic [3:0] OP_BIC  = 4'd8;
  localparam logic [3:0] OP_BIS  = 4'd9;
  localparam logic [3:0] OP_XOR  = 4'd10;
  localparam logic [3:0] OP_AND  = 4'd11;

  function automatic logic sgn(input logic [DW-1:0] x, input logic bm);
    return bm ? x[HW-1] : x[DW-1];
  endfunction

  logic [DW-1:0] mask, s_m, d_m, x_m;
  logic          is_sub, cin;
  logic [DW:0]   sum;
  logic          bin_cy;

  assign mask   = byte_mode ? {{(DW-HW){1'b0}}, {HW{1'b1}}} : {DW{1'b1}};
  assign s_m    = src & mask;
  assign d_m    = dst & mask;
  assign is_sub = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
  assign x_m    = is_sub ? (~src & mask) : s_m;
  assign cin    = (op == OP_ADD) ? 1'b0 :
                  ((op == OP_SUB) || (op == OP_CMP)) ? 1'b1 : carry_in;
  assign sum    = {1'b0, d_m} + {1'b0, x_m} + {{DW{1'b0}}, cin};
  assign bin_cy = byte_mode ? sum[HW] : sum[DW];

  logic [DW-1:0] dec_res;
  logic          dec_cy_half, dec_cy_full;

  always_comb begin
    logic [4:0] t;
    logic       cy;
    cy          = carry_in;
    dec_res     = '0;
    dec_cy_half = 1'b0;
    for (int i = 0; i < ND; i++) begin
      t = {1'b0, d_m[4*i +: 4]} + {1'b0, s_m[4*i +: 4]} + {4'b0, cy};
      if (t >= 5'd10) begin
        t  = t - 5'd10;
        cy = 1'b1;
      end else begin
        cy = 1'b0;
      end
      dec_res[4*i +: 4] = t[3:0];
      if (i == NDH - 1) dec_cy_half = cy;
    end
    dec_cy_full = cy;
  end

  logic [DW-1:0] n_res;
  logic          n_wb, n_v, n_c, n_n, n_z;
  logic [3:0]    n_en;

  always_comb begin
    n_res = '0;
    n_wb  = 1'b0;
    n_en  = 4'b0000;
    n_v   = 1'b0;
    n_c   = 1'b0;
    unique case (op)
      OP_MOV: begin
        n_res = s_m;
        n_wb  = 1'b1;
      end
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        n_res = sum[DW-1:0] & mask;
        n_wb  = (op != OP_CMP);
        n_en  = 4'b1111;
        n_c   = bin_cy;
        n_v   = (sgn(d_m, byte_mode) == sgn(x_m, byte_mode)) &&
                (sgn(n_res, byte_mode) != sgn(d_m, byte_mode));
      end
      OP_DADD: begin
        n_res = dec_res & mask;
        n_wb  = 1'b1;
        n_en  = 4'b1111;
        n_c   = byte_mode ? dec_cy_half : dec_cy_full;
        n_v   = (sgn(d_m, byte_mode) == sgn(s_m, byte_mode)) &&
                (sgn(n_res, byte_mode) != sgn(d_m, byte_mode));
      end
      OP_AND, OP_BIT: begin
        n_res = s_m & d_m;
        n_wb  = (op == OP_AND);
        n_en  = 4'b1111;
        n_c   = |n_res;
      end
      OP_XOR: begin
        n_res = s_m ^ d_m;
        n_wb  = 1'b1;
        n_en  = 4'b1111;
        n_c   = |n_res;
        n_v   = sgn(s_m, byte_mode) && sgn(d_m, byte_mode);
      end
      OP_BIC: begin
        n_res = ~s_m & d_m;
        n_wb  = 1'b1;
      end
      OP_BIS: begin
        n_res = s_m | d_m;
        n_wb  = 1'b1;
      end
      default: ;
    endcase
    n_n = sgn(n_res, byte_mode);
    n_z = (n_res == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !in_valid) begin
      out_valid <= 1'b0;
      result    <= '0;
      wb_en     <= 1'b0;
      {upd_v, upd_n, upd_z, upd_c}     <= 4'b0000;
      {flag_v, flag_n, flag_z, flag_c} <= 4'b0000;
    end else begin
      out_valid <= 1'b1;
      result    <= n_res;
      wb_en     <= n_wb;
      {upd_v, upd_n, upd_z, upd_c}     <= n_en;
      {flag_v, flag_n, flag_z, flag_c} <= {n_v, n_n, n_z, n_c} & n_en;
    end
  end

  // R10
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) == out_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wb_en && result == '0 &&
                    {upd_v, upd_n, upd_z, upd_c, flag_v, flag_n, flag_z, flag_c} == 8'h00));

  // R11
  flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_v -> !flag_v) && (!upd_n -> !flag_n) && (!upd_z -> !flag_z) && (!upd_c -> !flag_c));

  // R1
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && byte_mode) |-> result[DW-1:HW] == '0);

  // R5
  cmp_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && op == OP_CMP) |-> (!wb_en && upd_v && upd_n && upd_z && upd_c));

  // R7
  logic_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && (op == OP_AND || op == OP_BIT)) |-> (upd_v && !flag_v && flag_c == !flag_z));

  // R8
  setclr_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && (op == OP_BIC || op == OP_BIS || op == OP_MOV)) |->
      (wb_en && {upd_v, upd_n, upd_z, upd_c} == 4'b0000));

  // R12
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && op >= 4'd12) |->
      (out_valid && !wb_en && result == '0 && {upd_v, upd_n, upd_z, upd_c} == 4'b0000));
endmodule

// File: tb/dual_operand_alu_bench.sv
module dual_operand_alu_bench;
  typedef struct packed {
    logic [15:0] res;
    logic        wb;
    logic [3:0]  fl;
    logic [3:0]  en;
    logic [3:0]  op;
    logic        bm;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [3:0] op = '0;
  logic byte_mode = 1'b0;
  logic [15:0] src = '0, dst = '0;
  logic carry_in = 1'b0;
  logic out_valid, wb_en, flag_v, flag_n, flag_z, flag_c, upd_v, upd_n, upd_z, upd_c;
  logic [15:0] result;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;

  dual_operand_alu u_dual_operand_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .byte_mode(byte_mode),
    .src(src), .dst(dst), .carry_in(carry_in), .out_valid(out_valid), .result(result),
    .wb_en(wb_en), .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .upd_v(upd_v), .upd_n(upd_n), .upd_z(upd_z), .upd_c(upd_c));

  function automatic int bcd2int(input int x, input int nd);
    int v = 0, m = 1;
    for (int i = 0; i < nd; i++) begin
      v += ((x >> (4*i)) & 15) * m;
      m *= 10;
    end
    return v;
  endfunction

  function automatic int int2bcd(input int x, input int nd);
    int v = 0;
    for (int i = 0; i < nd; i++) begin
      v |= (x % 10) << (4*i);
      x /= 10;
    end
    return v;
  endfunction

  function automatic exp_t model(input logic [3:0] o, input logic bm,
                                 input logic [15:0] s, input logic [15:0] d, input logic ci);
    exp_t e;
    int w  = bm ? 8 : 16;
    int m  = 1 << w;
    int h  = m / 2;
    int sv = int'(s) & (m - 1);
    int dv = int'(d) & (m - 1);
    int tot = 0, r = 0, a2 = 0, lim = 0;
    bit v = 0, c = 0, all = 0, wb = 0;
    case (o)
      4'd0: begin r = sv; wb = 1; end                       // R2
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5: begin                   // R3 R4 R5
        a2  = (o >= 4'd3) ? (m - 1 - sv) : sv;
        tot = dv + a2 + ((o == 4'd1) ? 0 : (o == 4'd3 || o == 4'd5) ? 1 : int'(ci));
        r = tot % m; c = tot >= m;
        v = ((dv >= h) == (a2 >= h)) && ((r >= h) != (dv >= h));
        all = 1; wb = (o != 4'd5);
      end
      4'd6: begin                                           // R6
        lim = bm ? 100 : 10000;
        tot = bcd2int(dv, w/4) + bcd2int(sv, w/4) + int'(ci);
        c = tot >= lim; r = int2bcd(tot % lim, w/4);
        v = ((dv >= h) == (sv >= h)) && ((r >= h) != (dv >= h));
        all = 1; wb = 1;
      end
      4'd7, 4'd11: begin r = sv & dv; c = (r != 0); all = 1; wb = (o == 4'd11); end  // R7
      4'd8: begin r = (~sv) & dv & (m - 1); wb = 1; end    // R8
      4'd9: begin r = sv | dv; wb = 1; end                  // R8
      4'd10: begin r = sv ^ dv; c = (r != 0); v = (sv >= h) && (dv >= h); all = 1; wb = 1; end // R9
      default: ;                                            // R12
    endcase
    e.res = 16'(r);
    e.wb  = wb;
    e.en  = all ? 4'b1111 : 4'b0000;
    e.fl  = all ? {v, (r >= h), (r == 0), c} : 4'b0000;
    e.op  = o;
    e.bm  = bm;
    return e;
  endfunction

  function automatic string tag(input logic [3:0] o, input logic bm);
    string t;
    case (o)
      4'd0: t = "R2";
      4'd1, 4'd2: t = "R3";
      4'd3, 4'd4: t = "R4";
      4'd5: t = "R5";
      4'd6: t = "R6";
      4'd7, 4'd11: t = "R7";
      4'd8, 4'd9: t = "R8";
      4'd10: t = "R9";
      default: t = "R12";
    endcase
    return bm ? {t, "/R1"} : t;
  endfunction

  task automatic send(input logic [3:0] o, input logic bm, input logic [15:0] s,
                      input logic [15:0] d, input logic ci);
    @(negedge clk);
    in_valid = 1'b1; op = o; byte_mode = bm; src = s; dst = d; carry_in = ci;
    q.push_back(model(o, bm, s, d, ci));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; op = '0; src = '0; dst = '0; carry_in = 1'b0;
  endtask

  function automatic logic [15:0] rand_bcd();
    logic [15:0] x;
    for (int i = 0; i < 4; i++) x[4*i +: 4] = 4'($urandom % 10);
    return x;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        exp_t e, a;
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R10: out_valid=1 with no pending operation");
        end else begin
          e = q.pop_front();
          a = '{res: result, wb: wb_en, fl: {flag_v, flag_n, flag_z, flag_c},
                en: {upd_v, upd_n, upd_z, upd_c}, op: e.op, bm: e.bm};
          if (a != e) begin
            fails++;
            $display("FAIL %s op=%0d bm=%0d: got res=%h wb=%b vnzc=%b en=%b, expected res=%h wb=%b vnzc=%b en=%b",
                     tag(e.op, e.bm), e.op, e.bm, a.res, a.wb, a.fl, a.en, e.res, e.wb, e.fl, e.en);
          end
        end
      end else begin
        // R10 R11: idle cycle leaves everything low
        checks++;
        if (result != 0 || wb_en || {flag_v, flag_n, flag_z, flag_c, upd_v, upd_n, upd_z, upd_c} != 0) begin
          fails++;
          $display("FAIL R10: idle outputs res=%h wb=%b flags=%b, expected all zero", result, wb_en,
                   {flag_v, flag_n, flag_z, flag_c, upd_v, upd_n, upd_z, upd_c});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10: watchdog expired, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    checks++;
    if (out_valid || wb_en || result != 0 || {flag_v, flag_n, flag_z, flag_c, upd_v, upd_n, upd_z, upd_c} != 0) begin
      fails++;
      $display("FAIL R13: outputs during reset valid=%b res=%h, expected zero", out_valid, result);
    end
    rst_n = 1'b1;
    idle();

    // R3 signed overflow and carry/zero corners
    send(4'd1, 0, 16'h0001, 16'h7FFF, 0);
    send(4'd1, 0, 16'h0001, 16'hFFFF, 0);
    send(4'd2, 0, 16'h0000, 16'hFFFF, 1);
    // R1 byte corners with garbage in the upper byte
    send(4'd1, 1, 16'hAB01, 16'hCD7F, 0);
    send(4'd1, 1, 16'h1201, 16'h34FF, 0);
    send(4'd0, 1, 16'hBEEF, 16'h0000, 0);
    // R4 R5 subtract and compare
    send(4'd3, 0, 16'h1234, 16'h1234, 0);
    send(4'd3, 0, 16'h0001, 16'h8000, 0);
    send(4'd4, 1, 16'h0005, 16'h0003, 0);
    send(4'd5, 0, 16'h0002, 16'h0001, 0);
    idle();
    // R6 decimal carry limits
    send(4'd6, 0, 16'h0001, 16'h9999, 0);
    send(4'd6, 1, 16'h0001, 16'h0099, 0);
    send(4'd6, 1, 16'h0000, 16'h0199, 1);
    send(4'd6, 0, 16'h4567, 16'h1234, 1);
    // R7 R9 logic flags
    send(4'd11, 0, 16'h00F0, 16'h0F00, 0);
    send(4'd7, 0, 16'h8001, 16'h8000, 0);
    send(4'd10, 0, 16'h8000, 16'h8000, 0);
    send(4'd10, 1, 16'h0080, 16'h0001, 0);
    // R8 R12
    send(4'd8, 0, 16'h00FF, 16'hFFFF, 1);
    send(4'd9, 1, 16'hF00F, 16'h0F10, 1);
    send(4'd13, 0, 16'hFFFF, 16'hFFFF, 1);
    idle();

    for (int o = 0; o < 16; o++) begin
      for (int bm = 0; bm < 2; bm++) begin
        for (int k = 0; k < 30; k++) begin
          logic [15:0] s, d;
          s = (o == 6) ? rand_bcd() : 16'($urandom);
          d = (o == 6) ? rand_bcd() : 16'($urandom);
          send(4'(o), bm[0], s, d, 1'($urandom));
          if (k % 7 == 6) idle();
        end
      end
    end
    idle();
    idle();
    idle();
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R10: %0d results missing, expected 0", q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule